// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames out of a byte stream and into host memory through a ring of descriptors kept in that same memory. Software sets up the ring and loads its start address into the block. Each slot holds a flags word with an ownership bit and a capacity, and a word that points at the slot's data buffer. For each arriving frame the block fetches the slot at its current position. When hardware owns the slot, the block packs the frame bytes into 32-bit words and writes them to the buffer. It then writes the flags word back with ownership cleared and the stored length filled in, and moves to the next slot.

The length the block reports counts every byte it stores, and the stream carries the 4-byte frame check sequence as the last bytes of each frame. Software takes back a slot by re-arming it with ownership set. In the usual scheme it re-arms the slot one full ring ahead of the one it has just drained. A slot that software still holds makes the block discard the frame. A frame longer than the slot's capacity is cut short. Each case sets its own sticky status bit. The interrupt is level-sensitive: it is high while any status bit is set and the mask input is low.

The frame input is a valid/ready byte stream. A byte moves on a cycle where in_valid and in_ready are both high. A source that raises in_valid must hold it, with in_data and in_last, until the transfer happens. in_ready stays low while the block fetches a descriptor or writes to memory, and that is how the block applies back-pressure. The memory port holds each request stable until the cycle that mem_ack is high, and read data is taken in that cycle.

Top module: `rxr_desc_writer`

## Requirements
- R1: After reset, mem_req, in_ready, irq and every status bit are 0.
- R2: Slot i sits at base + 8*i. Its flags word is at offset 0 and its buffer pointer at offset 4. Bit 31 of the flags word is ownership, and bits 30:0 are the capacity in bytes, with values above 2^LEN_W-1 treated as 2^LEN_W-1. Every memory address is word aligned, and a request holds steady until it is acknowledged.
- R3: Frame byte k is written to buffer + k, in little-endian lane order within 32-bit words, with byte enables set only on the lanes that hold stored bytes. No other buffer byte is touched.
- R4: After the data, the flags word is rewritten with bit 31 = 0 and bits LEN_W-1:0 = the number of stored bytes, a count that includes the trailing 4 FCS bytes. All other bits are 0.
- R5: The slot position steps by one after each stored frame and wraps modulo 2^RING_LOG2.
- R6: When the fetched flags word has bit 31 = 0, the whole frame is consumed and discarded. Nothing is written to memory, status bit 1 (drop) is set, and the slot position stays where it was.
- R7: When a frame is longer than the capacity, only the first capacity bytes are stored. The length reports the capacity and status bit 2 (too small) is set. A frame that exactly fills the capacity does not set bit 2.
- R8: Status bit 0 (frame done) is set in the cycle after the flags write-back is acknowledged, and never earlier.
- R9: irq is high exactly when some status bit is 1 and irq_mask is 0. Writing clr_we with a 1 in clr_bits clears that status bit. A set in the same cycle as a clear wins.
- R10: in_ready is high only while the block accepts bytes of a frame into an owned slot or discards bytes of a dropped frame. It is low while idle and during every memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Block accepts a frame byte |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame (FCS included) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completes this cycle |
| base_we | input | 1 | Load the ring base address |
| base_din | input | AW | Ring base address (8-byte aligned) |
| irq_mask | input | 1 | 1 keeps irq low |
| clr_we | input | 1 | Write-one-to-clear strobe for status |
| clr_bits | input | 3 | Status bits to clear |
| status | output | 3 | Bit 0 done, bit 1 drop, bit 2 too small |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps frame lengths from 1 to 8 bytes across all four lane endings and runs the ring past its wrap point. A packer that closed a partial word badly would leave the tail bytes unwritten or write over the guard bytes that follow the frame. A frame that exactly fills its capacity is checked against one that runs past it, and a comparison that is off by one would raise the too-small bit on the first or miss it on the second. A slot that software still holds must take no memory write and must leave the slot position where it was. A design that advanced anyway would put the next frame into the wrong slot. The mask and write-one-to-clear paths are checked with a status bit pending.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_FLAGS,
    S_RD_BUFP,
    S_RECV,
    S_WR_DATA,
    S_WR_FLAGS,
    S_DROP
  } rxr_state_e;

  localparam int OWN_BIT    = 31;
  localparam int ST_DONE    = 0;
  localparam int ST_DROP    = 1;
  localparam int ST_SMALL   = 2;
  localparam int ST_W       = 3;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int RING_LOG2 = 4,
  parameter int AW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [AW-1:0] base_din,
  input  logic          advance,
  output logic [AW-1:0] flags_addr,
  output logic [AW-1:0] bufp_addr
);
  localparam int OFS_W = RING_LOG2 + 3;

  logic [AW-1:0]        base_q;
  logic [RING_LOG2-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else begin
      if (base_we) base_q <= base_din;
      if (advance) idx_q <= idx_q + 1'b1;  // wraps on power-of-two ring
    end
  end

  logic [OFS_W-1:0] slot_ofs;
  assign slot_ofs   = {idx_q, 3'b000};
  assign flags_addr = base_q + AW'(slot_ofs);
  assign bufp_addr  = flags_addr + AW'(4);
endmodule

// File: rtl/rxr_lane_pack.sv
module rxr_lane_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        put,
  input  logic [1:0]  lane,
  input  logic [7:0]  din,
  output logic [31:0] word,
  output logic [3:0]  be
);
  for (genvar g = 0; g < 4; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        word[8*g +: 8] <= '0;
        be[g]          <= 1'b0;
      end else if (put && lane == 2'(g)) begin
        word[8*g +: 8] <= din;
        be[g]          <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxr_status.sv
module rxr_status
  import rxr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_vec,
  input  logic            clr_we,
  input  logic [ST_W-1:0] clr_vec,
  input  logic            mask,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic [ST_W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~(clr_we ? clr_vec : '0)) | set_vec;
  end

  assign status = st_q;
  assign irq    = (|st_q) & ~mask;
endmodule

// File: rtl/rxr_desc_writer.sv
module rxr_desc_writer
  import rxr_pkg::*;
#(
  parameter int RING_LOG2 = 4,
  parameter int LEN_W     = 11,
  parameter int AW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          base_we,
  input  logic [AW-1:0] base_din,
  input  logic          irq_mask,
  input  logic          clr_we,
  input  logic [2:0]    clr_bits,
  output logic [2:0]    status,
  output logic          irq
);
  rxr_state_e       state_q;
  logic [LEN_W-1:0] cap_q, cnt_q, wofs_q;
  logic [AW-1:0]    buf_q;
  logic             ovf_q, end_q;

  logic [AW-1:0]    flags_addr, bufp_addr;
  logic [31:0]      pk_word;
  logic [3:0]       pk_be;
  logic             fire, room, put, flush, advance, pk_clr;
  logic [LEN_W-1:0] cnt_nx, cm1, cap_nx;
  logic [ST_W-1:0]  set_vec;

  assign in_ready = (state_q == S_RECV) || (state_q == S_DROP);
  assign fire     = in_valid && in_ready;
  assign room     = cnt_q < cap_q;
  assign put      = (state_q == S_RECV) && fire && room;
  assign cnt_nx   = cnt_q + LEN_W'(put);
  assign cm1      = cnt_nx - LEN_W'(1);
  assign flush    = (state_q == S_RECV) && fire &&
                    ((put && cnt_q[1:0] == 2'b11) || (in_last && (put || (|pk_be))));
  assign cap_nx   = (|mem_rdata[30:LEN_W]) ? '1 : mem_rdata[LEN_W-1:0];
  assign advance  = (state_q == S_WR_FLAGS) && mem_ack;
  assign pk_clr   = (state_q == S_WR_DATA) && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cap_q   <= '0;
      cnt_q   <= '0;
      wofs_q  <= '0;
      buf_q   <= '0;
      ovf_q   <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE:     if (in_valid) state_q <= S_RD_FLAGS;
        S_RD_FLAGS: if (mem_ack) begin
          if (mem_rdata[OWN_BIT]) begin
            cap_q   <= cap_nx;
            state_q <= S_RD_BUFP;
          end else begin
            state_q <= S_DROP;
          end
        end
        S_RD_BUFP: if (mem_ack) begin
          buf_q   <= mem_rdata;
          cnt_q   <= '0;
          ovf_q   <= 1'b0;
          end_q   <= 1'b0;
          state_q <= S_RECV;
        end
        S_RECV: if (fire) begin
          cnt_q <= cnt_nx;
          if (!room) ovf_q <= 1'b1;
          if (flush) begin
            wofs_q  <= cm1 & ~LEN_W'(3);
            end_q   <= in_last;
            state_q <= S_WR_DATA;
          end else if (in_last) begin
            state_q <= S_WR_FLAGS;
          end
        end
        S_WR_DATA:  if (mem_ack) state_q <= end_q ? S_WR_FLAGS : S_RECV;
        S_WR_FLAGS: if (mem_ack) state_q <= S_IDLE;
        S_DROP:     if (fire && in_last) state_q <= S_IDLE;
        default:    state_q <= S_IDLE;
      endcase
    end
  end

  // memory port, driven from state
  logic [31:0] flags_wb;
  always_comb begin
    flags_wb = '0;
    flags_wb[LEN_W-1:0] = cnt_q;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = flags_addr;
    mem_be    = 4'hF;
    mem_wdata = '0;
    unique case (state_q)
      S_RD_FLAGS: mem_req = 1'b1;
      S_RD_BUFP: begin
        mem_req  = 1'b1;
        mem_addr = bufp_addr;
      end
      S_WR_DATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_q + AW'(wofs_q);
        mem_be    = pk_be;
        mem_wdata = pk_word;
      end
      S_WR_FLAGS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = flags_wb;
      end
      default: ;
    endcase
  end

  always_comb begin
    set_vec           = '0;
    set_vec[ST_DONE]  = advance;
    set_vec[ST_SMALL] = advance && ovf_q;
    set_vec[ST_DROP]  = (state_q == S_DROP) && fire && in_last;
  end

  rxr_ring_ptr #(.RING_LOG2(RING_LOG2), .AW(AW)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_we    (base_we),
    .base_din   (base_din),
    .advance    (advance),
    .flags_addr (flags_addr),
    .bufp_addr  (bufp_addr)
  );

  rxr_lane_pack u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pk_clr),
    .put   (put),
    .lane  (cnt_q[1:0]),
    .din   (in_data),
    .word  (pk_word),
    .be    (pk_be)
  );

  rxr_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_we  (clr_we),
    .clr_vec (clr_bits),
    .mask    (irq_mask),
    .status  (status),
    .irq     (irq)
  );
endmodule

// File: rtl/rxr_desc_writer_chk.sv
module rxr_desc_writer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          irq_mask,
  input logic          clr_we,
  input logic [2:0]    clr_bits,
  input logic [2:0]    status,
  input logic          irq
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R2
  AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != 4'b0000); // R3
  AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(mem_req && mem_we && mem_ack)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq); // R9
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status != 3'b000); // R9
  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] && !(clr_we && clr_bits[1]) |=> status[1]); // R9
  AST_NO_READY_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready); // R10
endmodule

bind rxr_desc_writer rxr_desc_writer_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .mem_be   (mem_be),
  .irq_mask (irq_mask),
  .clr_we   (clr_we),
  .clr_bits (clr_bits),
  .status   (status),
  .irq      (irq)
);

// File: tb/tb_rxr_desc_writer.sv
module tb_rxr_desc_writer;
  localparam int RL = 2, LW = 11, AW = 32, NENT = 4;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] BUF0 = 32'h200;
  localparam int STRIDE = 64;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, in_ready;
  logic [7:0] in_data = 0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata = 0;
  logic base_we = 0, irq_mask = 0, clr_we = 0;
  logic [AW-1:0] base_din = 0;
  logic [2:0] clr_bits = 0, status;
  logic irq;

  int checks = 0, errors = 0, expidx = 0;
  logic [31:0] mem [0:1023];
  logic pk_we = 0;
  logic [31:0] pk_addr = 0, pk_data = 0;

  always #5 clk = ~clk;

  rxr_desc_writer #(.RING_LOG2(RL), .LEN_W(LW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .base_we(base_we),
    .base_din(base_din), .irq_mask(irq_mask), .clr_we(clr_we),
    .clr_bits(clr_bits), .status(status), .irq(irq));

  always @(posedge clk) begin
    if (pk_we) mem[pk_addr[11:2]] = pk_data;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] = mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  function automatic logic [7:0] getb(input logic [31:0] a);
    return mem[a[11:2]][8*a[1:0] +: 8];
  endfunction

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed + 7*k) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    pk_we = 1; pk_addr = a; pk_data = d;
    @(negedge clk);
    pk_we = 0;
  endtask

  task automatic arm(input int e, input int cap, input bit own);
    poke(BASE + 32'(8*e), {own, 31'(cap)});
    poke(BASE + 32'(8*e + 4), BUF0 + 32'(STRIDE*e));
    for (int w = 0; w < STRIDE/4; w++) poke(BUF0 + 32'(STRIDE*e + 4*w), 32'hEEEEEEEE);
  endtask

  task automatic clear_status();
    clr_we = 1; clr_bits = 3'b111;
    @(negedge clk);
    clr_we = 0; clr_bits = 0;
  endtask

  task automatic send(input int len, input int seed, input bit gaps);
    for (int k = 0; k < len; k++) begin
      in_valid = 1; in_data = pat(seed, k); in_last = (k == len-1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (gaps && (k % 3 == 1)) begin
        in_valid = 0;
        @(negedge clk);
      end
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic wait_status(input logic [2:0] m);
    for (int t = 0; t < 300 && ((status & m) == 0); t++) @(negedge clk);
  endtask

  task automatic check_frame(input int e, input int len, input int seed, input int cap, input string req);
    int stored;
    bit ok;
    stored = (len < cap) ? len : cap;
    chk(mem[(BASE + 32'(8*e)) >> 2] == 32'(stored), "R4 flags writeback",
        mem[(BASE + 32'(8*e)) >> 2], 32'(stored));
    ok = 1;
    for (int k = 0; k < stored; k++)
      if (getb(BUF0 + 32'(STRIDE*e + k)) != pat(seed, k)) ok = 0;
    chk(ok, {req, " R3 data bytes"}, 32'(len), 32'(stored));
    ok = 1;
    for (int j = 0; j < 4; j++)
      if (stored + j < STRIDE && getb(BUF0 + 32'(STRIDE*e + stored + j)) != 8'hEE) ok = 0;
    chk(ok, {req, " R3 guard bytes untouched"}, 32'(stored), 32'hEE);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!mem_req && !in_ready, "R1 port quiet", {30'd0, mem_req, in_ready}, 0);
    chk(status == 0 && !irq, "R1 status/irq", {28'd0, irq, status}, 0);
    rst_n = 1;
    @(negedge clk);
    base_we = 1; base_din = BASE;
    @(negedge clk);
    base_we = 0;
    for (int e = 0; e < NENT; e++) arm(e, STRIDE, 1);

    // R5 sweep of lengths across lane endings and ring wrap; len 64 = capacity exactly (R7)
    for (int f = 0; f < 9; f++) begin
      int len;
      len = (f < 8) ? f + 1 : STRIDE;
      arm(expidx, STRIDE, 1);
      clear_status();
      send(len, f*13 + 1, f[0]);
      wait_status(3'b001);
      chk(status == 3'b001, "R8/R7 done only", 32'(status), 1);
      chk(irq == 1, "R9 irq on done", 32'(irq), 1);
      chk(in_ready == 0, "R10 idle not ready", 32'(in_ready), 0);
      check_frame(expidx, len, f*13 + 1, STRIDE, "R5 sweep");
      expidx = (expidx + 1) % NENT;
    end

    // R9 mask and write-one-to-clear
    irq_mask = 1;
    @(negedge clk);
    chk(irq == 0, "R9 masked", 32'(irq), 0);
    irq_mask = 0;
    @(negedge clk);
    chk(irq == 1, "R9 unmasked", 32'(irq), 1);
    clear_status();
    chk(status == 0 && irq == 0, "R9 cleared", {28'd0, irq, status}, 0);

    // R7 truncation
    arm(expidx, 6, 1);
    send(11, 77, 0);
    wait_status(3'b001);
    chk(status == 3'b101, "R7 too-small status", 32'(status), 32'b101);
    check_frame(expidx, 11, 77, 6, "R7 truncate");
    expidx = (expidx + 1) % NENT;

    // R6 drop on a slot software still holds
    clear_status();
    arm(expidx, STRIDE, 0);
    send(5, 9, 1);
    wait_status(3'b010);
    chk(status == 3'b010, "R6 drop status", 32'(status), 32'b010);
    chk(mem[(BASE + 32'(8*expidx)) >> 2] == 32'(STRIDE), "R6 flags untouched",
        mem[(BASE + 32'(8*expidx)) >> 2], 32'(STRIDE));
    chk(mem[(BUF0 + 32'(STRIDE*expidx)) >> 2] == 32'hEEEEEEEE, "R6 buffer untouched",
        mem[(BUF0 + 32'(STRIDE*expidx)) >> 2], 32'hEEEEEEEE);
    arm(expidx, STRIDE, 1);
    clear_status();
    send(3, 40, 0);
    wait_status(3'b001);
    chk(status == 3'b001, "R6 next frame done", 32'(status), 1);
    check_frame(expidx, 3, 40, STRIDE, "R6 index held");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule